// File: doc/BRIEF.md
# Update-Protocol Coherence Line Controller

This block holds the coherence state of a small set of cache lines for one cache in a snooping multiprocessor that uses a four-state write-back update protocol. Each present line is exclusive-clean, shared-clean, shared-modified (the single owner among several copies) or modified. A separate present bit marks lines that are absent, so there is no invalid state. The processor side gives read, write and evict requests. The block decides between hit and miss and requests the bus. When it is granted, it issues a read, a single-word update or a write-back. A request finishes with a one-cycle done pulse.

On the snoop side the block watches transactions from other caches. For any line it holds, it asserts the shared response. As owner it supplies the data on a snooped read. It raises a word-write strobe so that a broadcast word lands in the local copy. A local word-write strobe (index, offset, data) goes to the data array. For a write that carries a bus update, this strobe rises only in the cycle the bus is granted. Arbitration lies outside the block. The grant comes in as an input, and the shared response of the other caches comes in as `bus_shared_in`, sampled in the grant cycle.

FSM states: `MS_IDLE` (wait for a request), `MS_DECIDE` (look up the line, settle hit or miss), `MS_FETCH` (bus read pending), `MS_BCAST` (word update pending), `MS_WBACK` (write-back pending), `MS_DONE` (done pulse). Transitions: IDLE→DECIDE on a request. DECIDE→DONE on a read hit, a write hit in exclusive-clean or modified, a silent drop, or a no-op. DECIDE→FETCH on any miss. DECIDE→BCAST on a write hit in a shared state. DECIDE→WBACK on evicting an owned line. FETCH→DONE after granting a read miss. FETCH→BCAST after granting a write miss. BCAST→DONE and WBACK→DONE on grant. DONE→IDLE always.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset every line is absent, `bus_req` and `req_done` are 0, and a snooped read of any line gives `snp_shared`=0 and `snp_flush`=0.
- R2: A read (`req_op`=0) to an absent line issues one bus read (`bus_cmd`=1). The line fills as shared-clean if `bus_shared_in` is 1 at the grant and as exclusive-clean otherwise. A read hit uses no bus.
- R3: A write (`req_op`=1) to an absent line issues a bus read followed by a bus update (`bus_cmd`=2). The line ends shared-modified if `bus_shared_in` is 1 at the update grant and modified otherwise.
- R4: A write hit in shared-clean or shared-modified issues one bus update whose `bus_idx`, `bus_ofs` and `bus_data` equal the request. The line becomes shared-modified if `bus_shared_in` is 1 at the grant and modified otherwise.
- R5: A write hit in exclusive-clean or modified issues no bus transaction, pulses the local word write once, and leaves the line modified.
- R6: A snooped read (`snp_cmd`=1) of a modified line asserts `snp_flush` and moves the line to shared-modified. Of a shared-modified line, it flushes and the line stays. Of an exclusive-clean line, it gives no flush and the line becomes shared-clean. Of a shared-clean line, nothing changes.
- R7: A snooped update (`snp_cmd`=2) of a shared-clean or shared-modified line asserts `snp_upd_we` in that cycle and leaves the line shared-clean.
- R8: `snp_shared` is 1 during a snooped read or update exactly when the line is present. A snoop to an absent line produces no response and no strobe.
- R9: An evict (`req_op`=2) drops an exclusive-clean or shared-clean line without a bus transaction. For a modified or shared-modified line it first issues a write-back (`bus_cmd`=3). Evicting an absent line does nothing. Afterwards the line is absent.
- R10: For a write that carries a bus update, the local word write is asserted only in the cycle `bus_gnt` is 1.
- R11: `bus_req` and `bus_cmd` stay stable until granted, `bus_cmd` is 0 while `bus_req` is 0, and `req_done` is a single-cycle pulse ending each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request strobe, accepted in idle |
| req_op | input | 2 | 0 read, 1 write, 2 evict, 3 no-op |
| req_idx | input | IDX_W | Line index |
| req_ofs | input | OFS_W | Word offset within the line |
| req_wdata | input | DATA_W | Write data word |
| req_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request, held until granted |
| bus_gnt | input | 1 | Bus grant; the transaction occurs in this cycle |
| bus_cmd | output | 2 | 0 none, 1 read, 2 word update, 3 write-back |
| bus_idx | output | IDX_W | Transaction line index |
| bus_ofs | output | OFS_W | Update word offset |
| bus_data | output | DATA_W | Update word |
| bus_shared_in | input | 1 | Shared response of other caches, sampled at grant |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_idx | input | IDX_W | Snooped line index |
| snp_ofs | input | OFS_W | Snooped word offset |
| snp_data | input | DATA_W | Snooped update word |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | This cache supplies the line as owner |
| snp_upd_we | output | 1 | Write `snp_data` at `snp_idx`/`snp_ofs` into the local copy |
| loc_we | output | 1 | Local word write strobe |
| loc_idx | output | IDX_W | Local write index |
| loc_ofs | output | OFS_W | Local write offset |
| loc_data | output | DATA_W | Local write data |

## Verification
The bench reads each line's hidden state only through normal traffic. A write hit tells exclusive-clean and modified (silent) apart from the shared states (an update goes out). A snooped read tells owners (flush) apart from clean copies. A design that left an exclusive line exclusive after a snooped read would later write silently and lose the other copy. One that kept a modified line modified after a flush would skip the next update. One that demoted a shared-modified line on a snooped read would lose the write-back on eviction. The bench delays grants and checks that the local word write never comes ahead of the grant. It also checks that a write miss sends both transactions and that evicting clean or absent lines stays off the bus.

// File: rtl/updc_pkg.sv
package updc_pkg;

    typedef enum logic [1:0] {
        LN_EXCL    = 2'd0,
        LN_SHCLEAN = 2'd1,
        LN_SHMOD   = 2'd2,
        LN_MOD     = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE      = 2'd0,
        BC_READ      = 2'd1,
        BC_UPDATE    = 2'd2,
        BC_WRITEBACK = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NOP   = 2'd3
    } cpu_op_e;

    typedef enum logic [2:0] {
        MS_IDLE   = 3'd0,
        MS_DECIDE = 3'd1,
        MS_FETCH  = 3'd2,
        MS_BCAST  = 3'd3,
        MS_WBACK  = 3'd4,
        MS_DONE   = 3'd5
    } mst_st_e;

endpackage

// File: rtl/updc_line_table.sv
module updc_line_table
    import updc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic             pres_a,
    output line_st_e         st_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic             pres_b,
    output line_st_e         st_b,
    input  logic             mw_en,
    input  logic [IDX_W-1:0] mw_idx,
    input  logic             mw_pres,
    input  line_st_e         mw_st,
    input  logic             sw_en,
    input  logic [IDX_W-1:0] sw_idx,
    input  line_st_e         sw_st
);

    logic     pres_q [NUM_LINES];
    line_st_e st_q   [NUM_LINES];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pres_q[i] <= 1'b0;
                st_q[i]   <= LN_EXCL;
            end else if (mw_en && mw_idx == IDX_W'(i)) begin
                pres_q[i] <= mw_pres;
                st_q[i]   <= mw_st;
            end else if (sw_en && sw_idx == IDX_W'(i)) begin
                st_q[i]   <= sw_st;
            end
        end
    end

    assign pres_a = pres_q[rd_idx_a];
    assign st_a   = st_q[rd_idx_a];
    assign pres_b = pres_q[rd_idx_b];
    assign st_b   = st_q[rd_idx_b];

endmodule

// File: rtl/updc_snoop_unit.sv
module updc_snoop_unit
    import updc_pkg::*;
(
    input  logic       snp_valid,
    input  logic [1:0] snp_cmd,
    input  logic       pres,
    input  line_st_e   st,
    output logic       shared,
    output logic       flush,
    output logic       upd_we,
    output logic       st_we,
    output line_st_e   st_nxt
);

    always_comb begin
        shared = 1'b0;
        flush  = 1'b0;
        upd_we = 1'b0;
        st_we  = 1'b0;
        st_nxt = st;
        if (snp_valid && pres) begin
            unique case (bus_cmd_e'(snp_cmd))
                BC_READ: begin
                    shared = 1'b1;
                    unique case (st)
                        LN_MOD: begin
                            flush  = 1'b1;
                            st_we  = 1'b1;
                            st_nxt = LN_SHMOD;
                        end
                        LN_SHMOD: flush = 1'b1;
                        LN_EXCL: begin
                            st_we  = 1'b1;
                            st_nxt = LN_SHCLEAN;
                        end
                        default: ;
                    endcase
                end
                BC_UPDATE: begin
                    shared = 1'b1;
                    if (st == LN_SHMOD || st == LN_SHCLEAN) begin
                        upd_we = 1'b1;
                        st_we  = 1'b1;
                        st_nxt = LN_SHCLEAN;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/updc_master_fsm.sv
module updc_master_fsm
    import updc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int WORDS     = 4,
    parameter int DATA_W    = 32,
    localparam int IDX_W = $clog2(NUM_LINES),
    localparam int OFS_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [OFS_W-1:0]  req_ofs,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_done,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic              lk_pres,
    input  line_st_e          lk_st,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [IDX_W-1:0]  bus_idx,
    output logic [OFS_W-1:0]  bus_ofs,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_shared_in,
    output logic              loc_we,
    output logic [IDX_W-1:0]  loc_idx,
    output logic [OFS_W-1:0]  loc_ofs,
    output logic [DATA_W-1:0] loc_data,
    output logic              tw_en,
    output logic [IDX_W-1:0]  tw_idx,
    output logic              tw_pres,
    output line_st_e          tw_st
);

    mst_st_e           state_q, state_d;
    cpu_op_e           op_q;
    logic [IDX_W-1:0]  idx_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [DATA_W-1:0] data_q;

    logic silent_wr;
    logic owned;
    assign silent_wr = lk_pres && (lk_st == LN_EXCL || lk_st == LN_MOD);
    assign owned     = lk_pres && (lk_st == LN_SHMOD || lk_st == LN_MOD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
            op_q    <= OP_NOP;
            idx_q   <= '0;
            ofs_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == MS_IDLE && req_valid) begin
                op_q   <= cpu_op_e'(req_op);
                idx_q  <= req_idx;
                ofs_q  <= req_ofs;
                data_q <= req_wdata;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE: if (req_valid) state_d = MS_DECIDE;
            MS_DECIDE: begin
                unique case (op_q)
                    OP_READ:  state_d = lk_pres ? MS_DONE : MS_FETCH;
                    OP_WRITE: state_d = !lk_pres ? MS_FETCH :
                                        (silent_wr ? MS_DONE : MS_BCAST);
                    OP_EVICT: state_d = owned ? MS_WBACK : MS_DONE;
                    default:  state_d = MS_DONE;
                endcase
            end
            MS_FETCH: if (bus_gnt) state_d = (op_q == OP_WRITE) ? MS_BCAST : MS_DONE;
            MS_BCAST: if (bus_gnt) state_d = MS_DONE;
            MS_WBACK: if (bus_gnt) state_d = MS_DONE;
            MS_DONE:  state_d = MS_IDLE;
            default:  state_d = MS_IDLE;
        endcase
    end

    assign lk_idx   = idx_q;
    assign tw_idx   = idx_q;
    assign loc_idx  = idx_q;
    assign loc_ofs  = ofs_q;
    assign loc_data = data_q;

    always_comb begin
        req_done = 1'b0;
        bus_req  = 1'b0;
        bus_cmd  = BC_NONE;
        bus_idx  = '0;
        bus_ofs  = '0;
        bus_data = '0;
        loc_we   = 1'b0;
        tw_en    = 1'b0;
        tw_pres  = 1'b1;
        tw_st    = LN_EXCL;
        unique case (state_q)
            MS_DECIDE: begin
                if (op_q == OP_WRITE && silent_wr) begin
                    loc_we = 1'b1;
                    tw_en  = 1'b1;
                    tw_st  = LN_MOD;
                end
                if (op_q == OP_EVICT && lk_pres && !owned) begin
                    tw_en   = 1'b1;
                    tw_pres = 1'b0;
                end
            end
            MS_FETCH: begin
                bus_req = 1'b1;
                bus_cmd = BC_READ;
                bus_idx = idx_q;
                if (bus_gnt) begin
                    tw_en = 1'b1;
                    tw_st = bus_shared_in ? LN_SHCLEAN : LN_EXCL;
                end
            end
            MS_BCAST: begin
                bus_req  = 1'b1;
                bus_cmd  = BC_UPDATE;
                bus_idx  = idx_q;
                bus_ofs  = ofs_q;
                bus_data = data_q;
                if (bus_gnt) begin
                    loc_we = 1'b1;
                    tw_en  = 1'b1;
                    tw_st  = bus_shared_in ? LN_SHMOD : LN_MOD;
                end
            end
            MS_WBACK: begin
                bus_req = 1'b1;
                bus_cmd = BC_WRITEBACK;
                bus_idx = idx_q;
                if (bus_gnt) begin
                    tw_en   = 1'b1;
                    tw_pres = 1'b0;
                end
            end
            MS_DONE: req_done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
    import updc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int WORDS     = 4,
    parameter int DATA_W    = 32,
    localparam int IDX_W = $clog2(NUM_LINES),
    localparam int OFS_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [OFS_W-1:0]  req_ofs,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [IDX_W-1:0]  bus_idx,
    output logic [OFS_W-1:0]  bus_ofs,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic [OFS_W-1:0]  snp_ofs,
    input  logic [DATA_W-1:0] snp_data,
    output logic              snp_shared,
    output logic              snp_flush,
    output logic              snp_upd_we,
    output logic              loc_we,
    output logic [IDX_W-1:0]  loc_idx,
    output logic [OFS_W-1:0]  loc_ofs,
    output logic [DATA_W-1:0] loc_data
);

    logic [IDX_W-1:0] lk_idx;
    logic             lk_pres, sn_pres;
    line_st_e         lk_st, sn_st;
    logic             tw_en, tw_pres;
    logic [IDX_W-1:0] tw_idx;
    line_st_e         tw_st;
    logic             sw_en;
    line_st_e         sw_st;

    // offset and data of a snooped update go straight to the data array;
    // the controller only qualifies them with snp_upd_we
    logic             unused_snp;
    assign unused_snp = ^{snp_ofs, snp_data};

    updc_line_table #(.NUM_LINES(NUM_LINES)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_a (lk_idx),
        .pres_a   (lk_pres),
        .st_a     (lk_st),
        .rd_idx_b (snp_idx),
        .pres_b   (sn_pres),
        .st_b     (sn_st),
        .mw_en    (tw_en),
        .mw_idx   (tw_idx),
        .mw_pres  (tw_pres),
        .mw_st    (tw_st),
        .sw_en    (sw_en),
        .sw_idx   (snp_idx),
        .sw_st    (sw_st)
    );

    updc_snoop_unit u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .pres      (sn_pres),
        .st        (sn_st),
        .shared    (snp_shared),
        .flush     (snp_flush),
        .upd_we    (snp_upd_we),
        .st_we     (sw_en),
        .st_nxt    (sw_st)
    );

    updc_master_fsm #(
        .NUM_LINES (NUM_LINES),
        .WORDS     (WORDS),
        .DATA_W    (DATA_W)
    ) u_master (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_idx       (req_idx),
        .req_ofs       (req_ofs),
        .req_wdata     (req_wdata),
        .req_done      (req_done),
        .lk_idx        (lk_idx),
        .lk_pres       (lk_pres),
        .lk_st         (lk_st),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .bus_cmd       (bus_cmd),
        .bus_idx       (bus_idx),
        .bus_ofs       (bus_ofs),
        .bus_data      (bus_data),
        .bus_shared_in (bus_shared_in),
        .loc_we        (loc_we),
        .loc_idx       (loc_idx),
        .loc_ofs       (loc_ofs),
        .loc_data      (loc_data),
        .tw_en         (tw_en),
        .tw_idx        (tw_idx),
        .tw_pres       (tw_pres),
        .tw_st         (tw_st)
    );

endmodule

// File: rtl/updc_checker.sv
module updc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic [1:0] bus_cmd,
    input logic       loc_we,
    input logic       snp_valid,
    input logic [1:0] snp_cmd,
    input logic       snp_shared,
    input logic       snp_flush,
    input logic       snp_upd_we,
    input logic       req_done
);

    AST_LOCAL_WRITE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_we && bus_req) |-> (bus_gnt && bus_cmd == 2'd2)); // R10

    AST_FLUSH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> (snp_valid && snp_cmd == 2'd1 && snp_shared)); // R6

    AST_UPD_STROBE_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        snp_upd_we |-> (snp_valid && snp_cmd == 2'd2 && snp_shared)); // R7

    AST_SHARED_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> snp_valid); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done); // R11

    AST_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (bus_cmd == 2'd0)); // R11

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd))); // R11

endmodule

bind upd_coh_ctrl updc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_cmd    (bus_cmd),
    .loc_we     (loc_we),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_shared (snp_shared),
    .snp_flush  (snp_flush),
    .snp_upd_we (snp_upd_we),
    .req_done   (req_done)
);

// File: tb/tb_upd_coh_ctrl.sv
module tb_upd_coh_ctrl;

    localparam int NL = 8;
    localparam int NW = 4;
    localparam int DW = 32;
    localparam int IW = $clog2(NL);
    localparam int OW = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [IW-1:0] req_idx = '0;
    logic [OW-1:0] req_ofs = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_done;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [1:0]    bus_cmd;
    logic [IW-1:0] bus_idx;
    logic [OW-1:0] bus_ofs;
    logic [DW-1:0] bus_data;
    logic          bus_shared_in = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [IW-1:0] snp_idx = '0;
    logic [OW-1:0] snp_ofs = '0;
    logic [DW-1:0] snp_data = '0;
    logic          snp_shared, snp_flush, snp_upd_we;
    logic          loc_we;
    logic [IW-1:0] loc_idx;
    logic [OW-1:0] loc_ofs;
    logic [DW-1:0] loc_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    upd_coh_ctrl #(.NUM_LINES(NL), .WORDS(NW), .DATA_W(DW)) dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // processor request; plays arbiter and other caches for each bus cycle
    task automatic cpu(input int op, input int idx, input int ofs, input int data,
                       input bit shared, input int gnt_delay,
                       output int n_rd, output int n_upd, output int n_wb,
                       output int n_lwe, output bit early, output bit pay_ok,
                       output bit done);
        int wait_cnt = 0;
        n_rd = 0; n_upd = 0; n_wb = 0; n_lwe = 0;
        early = 0; pay_ok = 1; done = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op[1:0]; req_idx = idx[IW-1:0];
        req_ofs = ofs[OW-1:0]; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 30; k++) begin
            #1;
            if (req_done) begin
                done = 1;
                break;
            end
            if (bus_req) begin
                if (loc_we) early = 1;
                if (wait_cnt < gnt_delay) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    if (bus_cmd == 2'd1) n_rd++;
                    if (bus_cmd == 2'd2) begin
                        n_upd++;
                        if (bus_idx != idx[IW-1:0] || bus_ofs != ofs[OW-1:0] ||
                            bus_data != data) pay_ok = 0;
                    end
                    if (bus_cmd == 2'd3) n_wb++;
                    bus_gnt = 1'b1; bus_shared_in = shared;
                    #1;
                    if (loc_we) n_lwe++;
                end
            end else if (loc_we) begin
                n_lwe++;
            end
            @(negedge clk);
            bus_gnt = 1'b0; bus_shared_in = 1'b0;
        end
    endtask

    task automatic snoop(input int cmd, input int idx, output bit sh, output bit fl,
                         output bit uw);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd[1:0]; snp_idx = idx[IW-1:0];
        snp_ofs = 2; snp_data = 32'hA5A5_0000 + idx;
        #1;
        sh = snp_shared; fl = snp_flush; uw = snp_upd_we;
        @(posedge clk);
        #1 snp_valid = 1'b0;
    endtask

    int r, u, w, l;
    bit e, p, d, sh, fl, uw;

    task automatic t_reset();
        chk(bus_req == 0 && req_done == 0, "R1 idle after reset", bus_req, 0);
        for (int i = 0; i < NL; i++) begin
            snoop(1, i, sh, fl, uw);
            chk(!sh && !fl, "R1 no line present", sh + fl, 0);
        end
    endtask

    task automatic t_excl_path();
        cpu(0, 1, 0, 0, 0, 0, r, u, w, l, e, p, d);
        chk(r == 1 && u == 0 && d, "R2 read miss one bus read", r, 1);
        cpu(0, 1, 0, 0, 0, 1, r, u, w, l, e, p, d);
        chk(r == 0 && d, "R2 read hit no bus", r, 0);
        cpu(1, 1, 1, 32'h11, 0, 0, r, u, w, l, e, p, d);
        chk(u == 0 && r == 0, "R5 write hit exclusive silent", u, 0);
        chk(l == 1, "R5 local strobe once", l, 1);
        snoop(1, 1, sh, fl, uw);
        chk(sh && fl, "R6 modified flushes", fl, 1);
        snoop(1, 1, sh, fl, uw);
        chk(fl, "R6 shared-modified keeps flushing", fl, 1);
        cpu(1, 1, 3, 32'h22, 0, 2, r, u, w, l, e, p, d);
        chk(u == 1 && p, "R4 update from shared-modified with payload", u, 1);
        chk(!e && l == 1, "R10 local write waits for grant", e, 0);
        cpu(1, 1, 0, 32'h33, 0, 0, r, u, w, l, e, p, d);
        chk(u == 0, "R4 alone after update so modified", u, 0);
        snoop(1, 1, sh, fl, uw);
        chk(fl, "R6 modified to shared-modified", fl, 1);
        cpu(1, 1, 2, 32'h44, 1, 0, r, u, w, l, e, p, d);
        chk(u == 1, "R4 shared-modified write updates", u, 1);
        snoop(2, 1, sh, fl, uw);
        chk(uw && sh && !fl, "R7 snooped update strobes", uw, 1);
        snoop(1, 1, sh, fl, uw);
        chk(sh && !fl, "R7 line left shared-clean", fl, 0);
    endtask

    task automatic t_shared_read();
        cpu(0, 2, 0, 0, 1, 1, r, u, w, l, e, p, d);
        chk(r == 1, "R2 shared read miss", r, 1);
        snoop(1, 2, sh, fl, uw);
        chk(sh && !fl, "R2 filled shared-clean", fl, 0);
        cpu(1, 2, 1, 32'h55, 1, 3, r, u, w, l, e, p, d);
        chk(u == 1 && p && !e && l == 1, "R4 shared-clean write broadcasts", u, 1);
        snoop(1, 2, sh, fl, uw);
        chk(fl, "R4 now shared-modified owner", fl, 1);
    endtask

    task automatic t_excl_snooped();
        cpu(0, 3, 0, 0, 0, 0, r, u, w, l, e, p, d);
        snoop(1, 3, sh, fl, uw);
        chk(sh && !fl, "R6 exclusive gives no flush", fl, 0);
        cpu(1, 3, 0, 32'h66, 0, 0, r, u, w, l, e, p, d);
        chk(u == 1, "R6 exclusive became shared-clean", u, 1);
        cpu(1, 3, 1, 32'h77, 0, 0, r, u, w, l, e, p, d);
        chk(u == 0, "R4 unshared update gives modified", u, 0);
    endtask

    task automatic t_write_miss();
        cpu(1, 4, 2, 32'h88, 0, 1, r, u, w, l, e, p, d);
        chk(r == 1 && u == 1 && p, "R3 write miss read then update", r * 10 + u, 11);
        chk(!e && l == 1, "R10 write miss local write at grant", l, 1);
        cpu(1, 4, 0, 32'h99, 0, 0, r, u, w, l, e, p, d);
        chk(u == 0 && r == 0, "R3 unshared write miss ends modified", u, 0);
        cpu(1, 5, 1, 32'hAA, 1, 0, r, u, w, l, e, p, d);
        chk(r == 1 && u == 1, "R3 shared write miss", r * 10 + u, 11);
        snoop(1, 5, sh, fl, uw);
        chk(fl, "R3 shared write miss owns line", fl, 1);
        cpu(1, 5, 3, 32'hBB, 1, 0, r, u, w, l, e, p, d);
        chk(u == 1, "R3 ended shared-modified not modified", u, 1);
    endtask

    task automatic t_evict();
        cpu(2, 2, 0, 0, 0, 1, r, u, w, l, e, p, d);
        chk(w == 1 && d, "R9 shared-modified written back", w, 1);
        snoop(1, 2, sh, fl, uw);
        chk(!sh, "R9 line absent after write-back", sh, 0);
        cpu(2, 3, 0, 0, 0, 0, r, u, w, l, e, p, d);
        chk(w == 1, "R9 modified written back", w, 1);
        cpu(2, 1, 0, 0, 0, 0, r, u, w, l, e, p, d);
        chk(w == 0 && r == 0 && u == 0, "R9 shared-clean silent drop", w, 0);
        snoop(1, 1, sh, fl, uw);
        chk(!sh, "R9 dropped line absent", sh, 0);
        cpu(0, 6, 0, 0, 0, 0, r, u, w, l, e, p, d);
        cpu(2, 6, 0, 0, 0, 0, r, u, w, l, e, p, d);
        chk(w == 0, "R9 exclusive silent drop", w, 0);
        cpu(2, 7, 0, 0, 0, 0, r, u, w, l, e, p, d);
        chk(w + r + u == 0 && d, "R9 absent evict no action", w + r + u, 0);
        cpu(0, 1, 0, 0, 0, 0, r, u, w, l, e, p, d);
        chk(r == 1, "R2 evicted line misses again", r, 1);
    endtask

    task automatic t_absent();
        snoop(2, 7, sh, fl, uw);
        chk(!uw && !sh, "R8 update to absent line ignored", uw + sh, 0);
        snoop(1, 6, sh, fl, uw);
        chk(!sh && !fl, "R8 read to absent line ignored", sh, 0);
        snoop(1, 4, sh, fl, uw);
        chk(sh && fl, "R8 present line answers shared", sh, 1);
    endtask

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_excl_path();
        t_shared_read();
        t_excl_snooped();
        t_write_miss();
        t_evict();
        t_absent();
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule